// File: doc/BRIEF.md
# Instruction Sequencer with Return Stack

This unit is the front end of a small 8-bit register machine whose instructions are 16 bits wide and sit in byte-addressed memory with a 12-bit address space. It reads each instruction with two byte reads. It sorts the instruction into one of three groups. Control-flow instructions are finished here: jumps, register-offset jump, subroutine call and return, and conditional skips. Instructions that belong to other units are dispatched with their decoded fields. Codes that no unit accepts are flagged as illegal.

Dispatch uses a valid/done handshake. `ex_valid` is high for exactly one cycle. The decoded fields then stay constant until the executing unit raises `ex_done`. That unit applies back-pressure by holding `ex_done` low. While it does so the sequencer issues no memory reads and the program counter does not move. An `ex_done` pulse that arrives while nothing is outstanding is ignored.

Return addresses are kept in an internal stack. `stk_depth` reports how many entries are filled. A call on a full stack, or a return on an empty one, is refused and sets a sticky error flag. Register values come from the surrounding register file through two select/data pairs and a dedicated V0 input.

Top module: `ifc_top`

## Requirements
- R1: While `rst_n` is low, `pc` is 0x200, `stk_depth` is 0, `stk_err` is 0, and `ex_valid` and `illegal` are 0.
- R2: Each instruction is fetched in two consecutive read cycles. The first read is at `pc` and returns the high byte. The second read is at `pc`+1, modulo 4096, and returns the low byte. `mem_rdata` is taken one cycle after the read request that asked for it.
- R3: The following are dispatched: 0x00E0; opcodes 6, 7, A, C and D; opcode 8 with low nibble 0–7 or E; opcode E with low byte 9E or A1; opcode F with low byte 07, 0A, 15, 18, 1E, 29, 33, 55 or 65. For each, `ex_valid` pulses for one cycle with `ex_op`=bits 15:12, `ex_x`=11:8, `ex_y`=7:4, `ex_n`=3:0, `ex_kk`=7:0 and `ex_nnn`=11:0. After `ex_done`, `pc` advances by 2.
- R4: 1nnn sets `pc` to nnn. Bnnn sets `pc` to V0+nnn, modulo 4096.
- R5: 2nnn on a stack that is not full pushes `pc`+2, raises `stk_depth` by one and sets `pc` to nnn.
- R6: 0x00EE on a stack that is not empty sets `pc` to the most recently pushed address and lowers `stk_depth` by one.
- R7: 3xkk advances `pc` by 4 when Vx equals kk, and by 2 otherwise. 4xkk advances by 4 when Vx differs from kk, and by 2 otherwise. Vx is read through `va_sel`=x.
- R8: 5xy0 advances `pc` by 4 when Vx equals Vy. 9xy0 advances `pc` by 4 when they differ. Otherwise each advances by 2. Vy is read through `vb_sel`=y. A nonzero low nibble on opcode 5 or 9 makes the instruction illegal.
- R9: A call with 16 entries filled, or a return with none filled, leaves `stk_depth` unchanged, sets `stk_err`, and advances `pc` by 2. `stk_err` then stays set until reset.
- R10: Every code not listed in R3–R8 raises `illegal` for one cycle, advances `pc` by 2, and is not dispatched.
- R11: `ex_done` is ignored unless a dispatched instruction is waiting for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 12 | Read byte address |
| mem_rdata | input | 8 | Read data, one cycle after the request |
| va_sel | output | 4 | Register select for Vx |
| va_data | input | 8 | Value of Vx |
| vb_sel | output | 4 | Register select for Vy |
| vb_data | input | 8 | Value of Vy |
| v0_data | input | 8 | Value of V0 |
| ex_valid | output | 1 | One-cycle dispatch strobe |
| ex_op | output | 4 | Dispatched opcode nibble |
| ex_x | output | 4 | Dispatched x field |
| ex_y | output | 4 | Dispatched y field |
| ex_n | output | 4 | Dispatched n field |
| ex_kk | output | 8 | Dispatched byte immediate |
| ex_nnn | output | 12 | Dispatched address field |
| ex_done | input | 1 | Executing unit has finished |
| pc | output | 12 | Program counter |
| stk_depth | output | 5 | Filled return-stack entries |
| stk_err | output | 1 | Sticky stack overflow/underflow flag |
| illegal | output | 1 | One-cycle illegal-instruction pulse |

## Verification
The bench aims at several corner cases. One is a register-offset jump that lands on the odd address 0xFFF, so the second byte comes from address 0. A design that does not wrap there, or that forces alignment, jumps to the wrong target. A second is a return on an empty stack and a run of self-calls that fills the stack. A pointer that wraps in either case changes the depth or corrupts later returns instead of raising the error. A third is skip comparisons on register values from a small range, so both outcomes happen often; a swapped sense or a wrong register select then shows up as a wrong `pc`. The last is stray `ex_done` pulses between dispatches and opcode 5/9 words with a nonzero low nibble. A design that acts on those pulses, or that treats those words as skips, gets ahead of the bench's model.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  localparam int INSN_W = 16;
  localparam int ADDR_W = 12;
  localparam int REG_W  = 8;

  // How the sequencer treats a decoded instruction.
  typedef enum logic [3:0] {
    K_DISP, K_JMP, K_JMPV0, K_CALL, K_RET,
    K_SEQI, K_SNEI, K_SEQR, K_SNER, K_ILL
  } kind_e;

  typedef struct packed {
    logic [3:0]        op;
    logic [3:0]        x;
    logic [3:0]        y;
    logic [3:0]        n;
    logic [REG_W-1:0]  kk;
    logic [ADDR_W-1:0] nnn;
  } fields_t;
endpackage

// File: rtl/ifc_decode.sv
module ifc_decode
  import ifc_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output fields_t           fld,
  output kind_e             kind
);
  always_comb begin
    fld.op  = insn[15:12];
    fld.x   = insn[11:8];
    fld.y   = insn[7:4];
    fld.n   = insn[3:0];
    fld.kk  = insn[7:0];
    fld.nnn = insn[11:0];
  end

  always_comb begin
    unique case (insn[15:12])
      4'h0: begin
        if (insn == 16'h00E0)      kind = K_DISP;
        else if (insn == 16'h00EE) kind = K_RET;
        else                       kind = K_ILL;
      end
      4'h1: kind = K_JMP;
      4'h2: kind = K_CALL;
      4'h3: kind = K_SEQI;
      4'h4: kind = K_SNEI;
      4'h5: kind = (insn[3:0] == 4'h0) ? K_SEQR : K_ILL;
      4'h9: kind = (insn[3:0] == 4'h0) ? K_SNER : K_ILL;
      4'hB: kind = K_JMPV0;
      4'h8: kind = (insn[3:0] <= 4'h7 || insn[3:0] == 4'hE) ? K_DISP : K_ILL;
      4'hE: kind = (insn[7:0] == 8'h9E || insn[7:0] == 8'hA1) ? K_DISP : K_ILL;
      4'hF: kind = (insn[7:0] inside {8'h07, 8'h0A, 8'h15, 8'h18, 8'h1E,
                                      8'h29, 8'h33, 8'h55, 8'h65}) ? K_DISP : K_ILL;
      default: kind = K_DISP;
    endcase
  end
endmodule

// File: rtl/ifc_skip.sv
module ifc_skip
  import ifc_pkg::*;
(
  input  kind_e            kind,
  input  logic [REG_W-1:0] a,
  input  logic [REG_W-1:0] b,
  input  logic [REG_W-1:0] imm,
  output logic             take
);
  always_comb begin
    unique case (kind)
      K_SEQI:  take = (a == imm);
      K_SNEI:  take = (a != imm);
      K_SEQR:  take = (a == b);
      K_SNER:  take = (a != b);
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/ifc_rstack.sv
module ifc_rstack #(
  parameter  int DEPTH = 16,
  parameter  int AW    = 12,
  localparam int DW    = $clog2(DEPTH + 1),
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic [AW-1:0] push_data,
  output logic [AW-1:0] top_data,
  output logic [DW-1:0] depth,
  output logic          full,
  output logic          empty,
  output logic          err
);
  logic [AW-1:0] slot_q [DEPTH];
  logic [DW-1:0] depth_q;
  logic [DW-1:0] below;
  logic          err_q;

  assign full     = (depth_q == DW'(DEPTH));
  assign empty    = (depth_q == '0);
  assign below    = depth_q - DW'(1);
  assign top_data = slot_q[below[IW-1:0]];
  assign depth    = depth_q;
  assign err      = err_q;

  // Depth counts filled slots; a refused access leaves it untouched.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
      err_q   <= 1'b0;
    end else if (push_req) begin
      if (full) err_q   <= 1'b1;
      else      depth_q <= depth_q + DW'(1);
    end else if (pop_req) begin
      if (empty) err_q   <= 1'b1;
      else       depth_q <= below;
    end
  end

  always_ff @(posedge clk) begin
    if (push_req && !full) slot_q[depth_q[IW-1:0]] <= push_data;
  end
endmodule

// File: rtl/ifc_top.sv
module ifc_top
  import ifc_pkg::*;
#(
  parameter  int               STK_DEPTH = 16,
  parameter  logic [ADDR_W-1:0] BOOT_PC  = 12'h200,
  localparam int               SDW       = $clog2(STK_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [REG_W-1:0]  mem_rdata,
  output logic [3:0]        va_sel,
  input  logic [REG_W-1:0]  va_data,
  output logic [3:0]        vb_sel,
  input  logic [REG_W-1:0]  vb_data,
  input  logic [REG_W-1:0]  v0_data,
  output logic              ex_valid,
  output logic [3:0]        ex_op,
  output logic [3:0]        ex_x,
  output logic [3:0]        ex_y,
  output logic [3:0]        ex_n,
  output logic [REG_W-1:0]  ex_kk,
  output logic [ADDR_W-1:0] ex_nnn,
  input  logic              ex_done,
  output logic [ADDR_W-1:0] pc,
  output logic [SDW-1:0]    stk_depth,
  output logic              stk_err,
  output logic              illegal
);
  typedef enum logic [2:0] {S_FHI, S_FLO, S_LAT, S_ACT, S_WAIT} st_e;

  st_e               st_q, st_nxt;
  logic [ADDR_W-1:0] pc_q, pc_nxt, pc_seq;
  logic [REG_W-1:0]  hi_q;
  logic [INSN_W-1:0] ir_q;
  fields_t           fld;
  kind_e             kind;
  logic              take, in_act;
  logic              push_req, pop_req, stk_full, stk_empty;
  logic [ADDR_W-1:0] top_data;

  ifc_decode u_dec (.insn(ir_q), .fld(fld), .kind(kind));

  ifc_skip u_skip (
    .kind(kind), .a(va_data), .b(vb_data), .imm(fld.kk), .take(take)
  );

  ifc_rstack #(.DEPTH(STK_DEPTH), .AW(ADDR_W)) u_stk (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
    .push_data(pc_seq), .top_data(top_data), .depth(stk_depth),
    .full(stk_full), .empty(stk_empty), .err(stk_err)
  );

  assign pc_seq   = pc_q + ADDR_W'(2);
  assign in_act   = (st_q == S_ACT);
  assign push_req = in_act && (kind == K_CALL);
  assign pop_req  = in_act && (kind == K_RET);

  assign mem_req  = (st_q == S_FHI) || (st_q == S_FLO);
  assign mem_addr = (st_q == S_FLO) ? pc_q + ADDR_W'(1) : pc_q;

  assign va_sel   = fld.x;
  assign vb_sel   = fld.y;
  assign ex_valid = in_act && (kind == K_DISP);
  assign illegal  = in_act && (kind == K_ILL);
  assign ex_op    = fld.op;
  assign ex_x     = fld.x;
  assign ex_y     = fld.y;
  assign ex_n     = fld.n;
  assign ex_kk    = fld.kk;
  assign ex_nnn   = fld.nnn;
  assign pc       = pc_q;

  always_comb begin
    pc_nxt = pc_q;
    st_nxt = st_q;
    unique case (st_q)
      S_FHI: st_nxt = S_FLO;
      S_FLO: st_nxt = S_LAT;
      S_LAT: st_nxt = S_ACT;
      S_ACT: begin
        st_nxt = S_FHI;
        unique case (kind)
          K_DISP:  st_nxt = S_WAIT;
          K_JMP:   pc_nxt = fld.nnn;
          K_JMPV0: pc_nxt = fld.nnn + {{(ADDR_W-REG_W){1'b0}}, v0_data};
          K_CALL:  pc_nxt = stk_full  ? pc_seq : fld.nnn;
          K_RET:   pc_nxt = stk_empty ? pc_seq : top_data;
          K_SEQI, K_SNEI, K_SEQR, K_SNER:
                   pc_nxt = take ? pc_seq + ADDR_W'(2) : pc_seq;
          default: pc_nxt = pc_seq;
        endcase
      end
      S_WAIT: begin
        if (ex_done) begin
          pc_nxt = pc_seq;
          st_nxt = S_FHI;
        end
      end
      default: st_nxt = S_FHI;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_FHI;
      pc_q <= BOOT_PC;
      hi_q <= '0;
      ir_q <= '0;
    end else begin
      st_q <= st_nxt;
      pc_q <= pc_nxt;
      if (st_q == S_FLO) hi_q <= mem_rdata;
      if (st_q == S_LAT) ir_q <= {hi_q, mem_rdata};
    end
  end
endmodule

// File: rtl/ifc_check.sv
module ifc_check #(
  parameter  int DEPTH = 16,
  localparam int SDW   = $clog2(DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_req,
  input logic [11:0]    mem_addr,
  input logic           ex_valid,
  input logic [11:0]    ex_nnn,
  input logic [11:0]    pc,
  input logic [SDW-1:0] stk_depth,
  input logic           stk_err,
  input logic           illegal
);
  // R2
  fetch_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !$past(mem_req)) |=> (mem_req && mem_addr == $past(mem_addr) + 12'd1));

  // R3
  ex_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid |=> !ex_valid);

  // R3
  ex_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid |=> $stable(ex_nnn));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err |=> stk_err);

  // R9
  err_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stk_err) |-> $stable(stk_depth));

  // R9
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_depth <= SDW'(DEPTH));

  // R5
  depth_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stk_depth == $past(stk_depth) ||
              stk_depth == $past(stk_depth) + SDW'(1) ||
              stk_depth == $past(stk_depth) - SDW'(1)));

  // R10
  ill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> pc == $past(pc) + 12'd2);

  // R10
  ill_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(illegal && ex_valid));
endmodule

bind ifc_top ifc_check #(.DEPTH(STK_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
  .ex_valid(ex_valid), .ex_nnn(ex_nnn), .pc(pc), .stk_depth(stk_depth),
  .stk_err(stk_err), .illegal(illegal)
);

// File: tb/sim_ifc_top.sv
module sim_ifc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req;
  logic [11:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;
  logic [3:0]  va_sel, vb_sel;
  logic [7:0]  va_data, vb_data, v0_data;
  logic        ex_valid, ex_done, stk_err, illegal;
  logic [3:0]  ex_op, ex_x, ex_y, ex_n;
  logic [7:0]  ex_kk;
  logic [11:0] ex_nnn, pc;
  logic [4:0]  stk_depth;

  logic [7:0]  mem [4096];
  logic [7:0]  vr [16];

  always #4 clk = ~clk;

  assign va_data = vr[va_sel];
  assign vb_data = vr[vb_sel];
  assign v0_data = vr[0];

  always @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr];

  ifc_top u0 (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .va_sel(va_sel), .va_data(va_data),
    .vb_sel(vb_sel), .vb_data(vb_data), .v0_data(v0_data),
    .ex_valid(ex_valid), .ex_op(ex_op), .ex_x(ex_x), .ex_y(ex_y),
    .ex_n(ex_n), .ex_kk(ex_kk), .ex_nnn(ex_nnn), .ex_done(ex_done),
    .pc(pc), .stk_depth(stk_depth), .stk_err(stk_err), .illegal(illegal)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference state computed from the requirements.
  logic [11:0] m_pc;
  int          m_depth, m_ill, ill_seen;
  bit          m_err, m_disp;
  logic [11:0] m_stk [16];
  logic [15:0] m_word;
  string       m_tag;

  task automatic model_exec();
    logic [3:0]  op  = m_word[15:12];
    logic [3:0]  x   = m_word[11:8];
    logic [3:0]  y   = m_word[7:4];
    logic [3:0]  n   = m_word[3:0];
    logic [7:0]  kk  = m_word[7:0];
    logic [11:0] nnn = m_word[11:0];
    logic [11:0] seq = m_pc + 12'd2;
    bit ill = 0;
    m_disp = 0;
    if (m_word == 16'h00E0) begin m_disp = 1; m_tag = "R3/R11"; end
    else if (m_word == 16'h00EE) begin
      if (m_depth == 0) begin m_err = 1; m_pc = seq; m_tag = "R9"; end
      else begin m_depth--; m_pc = m_stk[m_depth]; m_tag = "R6"; end
    end else begin
      case (op)
        4'h0: ill = 1;
        4'h1: begin m_pc = nnn; m_tag = "R4"; end
        4'h2: begin
          if (m_depth == 16) begin m_err = 1; m_pc = seq; m_tag = "R9"; end
          else begin m_stk[m_depth] = seq; m_depth++; m_pc = nnn; m_tag = "R5"; end
        end
        4'h3: begin m_pc = (vr[x] == kk) ? seq + 12'd2 : seq; m_tag = "R7"; end
        4'h4: begin m_pc = (vr[x] != kk) ? seq + 12'd2 : seq; m_tag = "R7"; end
        4'h5: if (n != 0) ill = 1;
              else begin m_pc = (vr[x] == vr[y]) ? seq + 12'd2 : seq; m_tag = "R8"; end
        4'h9: if (n != 0) ill = 1;
              else begin m_pc = (vr[x] != vr[y]) ? seq + 12'd2 : seq; m_tag = "R8"; end
        4'hB: begin m_pc = nnn + {4'h0, vr[0]}; m_tag = "R4"; end
        4'h8: if (n <= 4'h7 || n == 4'hE) m_disp = 1; else ill = 1;
        4'hE: if (kk == 8'h9E || kk == 8'hA1) m_disp = 1; else ill = 1;
        4'hF: if (kk inside {8'h07, 8'h0A, 8'h15, 8'h18, 8'h1E, 8'h29,
                             8'h33, 8'h55, 8'h65}) m_disp = 1;
              else ill = 1;
        default: m_disp = 1;
      endcase
    end
    if (m_disp) begin m_pc = seq; m_tag = "R3/R11"; end
    if (ill) begin m_ill++; m_pc = seq; m_tag = "R10"; end
  endtask

  // Executing-unit stand-in: answers dispatches after 1..4 cycles and
  // drops stray done pulses between them, which must be ignored (R11).
  initial begin
    ex_done = 1'b0;
    forever begin
      @(negedge clk);
      ex_done = 1'b0;
      if (ex_valid) begin
        repeat ($urandom_range(1, 4)) @(negedge clk);
        ex_done = 1'b1;
      end else if (rst_n && $urandom_range(0, 9) == 0) begin
        ex_done = 1'b1;
      end
    end
  end

  task automatic run_fetches(int count, bit rnd);
    int got = 0;
    bit prev_req = 0;
    bit lo_due = 0;
    logic [11:0] lo_exp = '0;
    while (got < count) begin
      if (lo_due) chk(mem_req && mem_addr == lo_exp, "R2", "second read addr", int'(mem_addr), int'(lo_exp));
      lo_due = 0;
      if (illegal) ill_seen++;
      if (ex_valid) begin
        chk(m_disp, "R3", "dispatch expected", 1, int'(m_disp));
        chk({ex_op, ex_x, ex_y, ex_n} == m_word, "R3", "fields",
            int'({ex_op, ex_x, ex_y, ex_n}), int'(m_word));
        chk(ex_kk == m_word[7:0] && ex_nnn == m_word[11:0], "R3", "kk/nnn",
            int'({ex_kk, ex_nnn}), int'({m_word[7:0], m_word[11:0]}));
      end
      if (mem_req && !prev_req) begin
        chk(mem_addr == m_pc && pc == m_pc, m_tag, "pc at fetch", int'(pc), int'(m_pc));
        chk(int'(stk_depth) == m_depth, m_tag, "stack depth", int'(stk_depth), m_depth);
        chk(stk_err == m_err, "R9", "stk_err", int'(stk_err), int'(m_err));
        chk(ill_seen == m_ill, "R10", "illegal pulses", ill_seen, m_ill);
        got++;
        if (rnd) begin
          for (int i = 0; i < 16; i++)
            vr[i] = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'($urandom_range(0, 3));
        end
        m_word = {mem[m_pc], mem[m_pc + 12'd1]};
        lo_exp = m_pc + 12'd1;
        lo_due = 1;
        model_exec();
      end
      prev_req = mem_req;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(pc == 12'h200, "R1", "reset pc", int'(pc), 'h200);
    chk(stk_depth == 0 && !stk_err, "R1", "reset stack", int'({stk_err, stk_depth}), 0);
    chk(!ex_valid && !illegal, "R1", "reset strobes", int'({ex_valid, illegal}), 0);
    m_pc = 12'h200; m_depth = 0; m_err = 0; m_ill = 0; ill_seen = 0;
    m_disp = 0; m_tag = "R1";
    rst_n = 1'b1;
  endtask

  function automatic logic [15:0] gen_word();
    int r = $urandom_range(0, 99);
    logic [15:0] w = 16'($urandom);
    if (r < 7) return 16'h00EE;
    if (r < 10) return 16'h00E0;
    if (w[15:12] == 4'h3 || w[15:12] == 4'h4) w[7:0] = 8'($urandom_range(0, 3));
    if ((w[15:12] == 4'h5 || w[15:12] == 4'h9) && $urandom_range(0, 3) != 0) w[3:0] = 4'h0;
    return w;
  endfunction

  task automatic put(logic [11:0] a, logic [15:0] w);
    mem[a] = w[15:8];
    mem[a + 12'd1] = w[7:0];
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    for (int i = 0; i < 16; i++) vr[i] = 8'h00;

    // Directed: call/return, both skip kinds, illegal forms, underflow,
    // Bnnn landing on 0xFFF so the low byte wraps to address 0.
    vr[0] = 8'h01; vr[1] = 8'h05; vr[2] = 8'h05;
    put(12'h200, 16'h2300); put(12'h300, 16'h00E0); put(12'h302, 16'h00EE);
    put(12'h202, 16'h3001); put(12'h206, 16'h4105); put(12'h208, 16'h5120);
    put(12'h20C, 16'h9120); put(12'h20E, 16'h5121); put(12'h210, 16'h0123);
    put(12'h212, 16'h00EE); put(12'h214, 16'h8AB9); put(12'h216, 16'hF0FF);
    put(12'h218, 16'hE09E); put(12'h21A, 16'hBFFE);
    mem[12'hFFF] = 8'h12; mem[12'h000] = 8'h20;
    put(12'h220, 16'h1220);
    do_reset();
    run_fetches(18, 0);

    // Directed: self-call fills the stack, 17th call overflows.
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    put(12'h200, 16'h2200); put(12'h202, 16'h1202);
    do_reset();
    run_fetches(20, 0);

    // Constrained random program over the whole address space.
    for (int a = 0; a < 4096; a += 2) put(12'(a), gen_word());
    do_reset();
    run_fetches(2500, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=progress");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule